// File: doc/BRIEF.md
# Dithered Sine Synthesiser with Two Samples per Clock

This block is a direct digital synthesiser. A 48-bit phase register advances by a frequency tuning word on every system clock. The four most significant phase bits select one of sixteen 5-bit sine samples. The samples are stored in offset binary around a mid-scale of 16. Each sample is reduced to 4 bits. The block adds one pseudo-random bit at the position of the bit that is dropped, shifts right by one, and clamps the result at 15. This spreads the quantisation error into noise instead of leaving it as fixed harmonics.

Every clock produces two 4-bit words. The rising-edge word comes from the current phase. The falling-edge word comes from the current phase plus half the tuning word, which puts it midway to the next phase. A double-data-rate output register outside this block sends the two words to an external resistor-ladder DAC, so the sample rate is twice the system clock. The stream runs freely and has no handshake. The converter takes one word on every clock edge, so back-pressure cannot exist. A new word is registered on every clock that is not in reset.

Top module: `dithered_sine_dds`

## Requirements
- R1: On each clock edge with `rst` low, the phase register adds `ftw` modulo 2^48. A tuning word of zero holds the phase.
- R2: The sample table, in order of index 0 to 15, is 16, 22, 27, 30, 31, 30, 27, 22, 16, 10, 5, 2, 1, 2, 5, 10. The table index is phase bits [47:44].
- R3: Each output word is (table sample + dither bit) shifted right by one bit.
- R4: When the table sample is 31 and the dither bit is 1, the output word is clamped to 15.
- R5: Dither bits come from a 16-bit shift register that shifts left by one position. The bit shifted in is the XOR of bits 15, 13, 12 and 10. The register steps twice per clock. The first new bit dithers the rising-edge word and the second dithers the falling-edge word.
- R6: `samp_rise` is built from phase P. `samp_fall` is built from (P + floor(ftw/2)) mod 2^48. Here P is the phase before the same clock edge and ftw is the word present at that edge. Both outputs are registered.
- R7: A synchronous reset sets the phase to 0, loads the dither register with 16'hACE1, and sets both outputs to 8.
- R8: A change of `ftw` only changes later phase increments. The phase built up so far is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ftw | input | 48 | Frequency tuning word added to the phase each clock |
| samp_rise | output | 4 | Word for the rising-edge half of the output cycle |
| samp_fall | output | 4 | Word for the falling-edge half of the output cycle |

## Verification
The bench builds the block with its default 48-bit phase. It chooses tuning words whose few set bits are at or just below bit 44. One step of 2^44 visits every table entry in order, so all sixteen samples and the clamp case at entry 4 are reached within a few hundred clocks. A step of 2^43 makes the two lanes fall on different entries. A step of 2^47 and a step of all ones (one step backwards) exercise wrap-around. A tuning word of zero checks that the phase holds. A dense odd word and a mid-run reset check that the phase and the dither sequence continue or restart as expected.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int SMP_W   = 5;
  localparam int OUT_W   = 4;
  localparam int IDX_W   = 4;
  localparam int LFSR_W  = 16;
  localparam int LANES   = 2;
  localparam logic [SMP_W-1:0] MID_SMP = 5'd16;
  localparam logic [OUT_W-1:0] MID_OUT = 4'd8;
  localparam logic [OUT_W-1:0] OUT_MAX = {OUT_W{1'b1}};
  localparam logic [LFSR_W-1:0] TAP_MASK = 16'hB400;

  // quarter-wave magnitudes, amplitude 15
  function automatic logic [SMP_W-1:0] quarter_mag(input logic [2:0] j);
    case (j)
      3'd0:    return 5'd0;
      3'd1:    return 5'd6;
      3'd2:    return 5'd11;
      3'd3:    return 5'd14;
      default: return 5'd15;
    endcase
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & TAP_MASK)};
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_pkg::*;
#(
  parameter int PHASE_W = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] ftw,
  output logic [IDX_W-1:0]   idx_now,
  output logic [IDX_W-1:0]   idx_mid
);
  localparam int TOP = PHASE_W - 1;
  localparam int LOW = PHASE_W - IDX_W;

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_mid;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + ftw;
  end

  assign phase_mid = phase_q + (ftw >> 1);
  assign idx_now   = phase_q[TOP:LOW];
  assign idx_mid   = phase_mid[TOP:LOW];
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
  import dds_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output logic [SMP_W-1:0] smp
);
  logic [2:0]       in_half;
  logic [2:0]       fold;
  logic [SMP_W-1:0] mag;

  always_comb begin
    in_half = idx[2:0];
    fold    = (idx[2:0] > 3'd4) ? 3'(4'd8 - {1'b0, idx[2:0]}) : in_half;
    mag     = quarter_mag(fold);
    smp     = idx[3] ? (MID_SMP - mag) : (MID_SMP + mag);
  end
endmodule

// File: rtl/dds_dither_lfsr.sv
module dds_dither_lfsr
  import dds_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [LANES-1:0] dbit
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] chain [LANES+1];

  assign chain[0] = state_q;

  for (genvar g = 0; g < LANES; g++) begin : g_step
    assign chain[g+1] = lfsr_next(chain[g]);
    assign dbit[g]    = chain[g+1][0];
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= chain[LANES];
  end
endmodule

// File: rtl/dds_dither_lane.sv
module dds_dither_lane
  import dds_pkg::*;
(
  input  logic [SMP_W-1:0] smp,
  input  logic             dbit,
  output logic [OUT_W-1:0] word
);
  logic [SMP_W:0] sum;

  always_comb begin
    sum  = {1'b0, smp} + {{SMP_W{1'b0}}, dbit};
    word = sum[SMP_W] ? OUT_MAX : sum[SMP_W-1:1];
  end
endmodule

// File: rtl/dithered_sine_dds.sv
module dithered_sine_dds
  import dds_pkg::*;
#(
  parameter int                PHASE_W = 48,
  parameter logic [LFSR_W-1:0] SEED    = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] ftw,
  output logic [OUT_W-1:0]   samp_rise,
  output logic [OUT_W-1:0]   samp_fall
);
  logic [IDX_W-1:0] lane_idx  [LANES];
  logic [SMP_W-1:0] lane_smp  [LANES];
  logic [OUT_W-1:0] lane_word [LANES];
  logic [LANES-1:0] lane_dbit;
  logic [OUT_W-1:0] word_q    [LANES];

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .ftw     (ftw),
    .idx_now (lane_idx[0]),
    .idx_mid (lane_idx[1])
  );

  dds_dither_lfsr #(.SEED(SEED)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .dbit (lane_dbit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dds_sine_rom u_rom (
      .idx (lane_idx[g]),
      .smp (lane_smp[g])
    );
    dds_dither_lane u_dith (
      .smp  (lane_smp[g]),
      .dbit (lane_dbit[g]),
      .word (lane_word[g])
    );
    always_ff @(posedge clk) begin
      if (rst) word_q[g] <= MID_OUT;
      else     word_q[g] <= lane_word[g];
    end
  end

  assign samp_rise = word_q[0];
  assign samp_fall = word_q[1];
endmodule

// File: rtl/dds_checker.sv
module dds_checker
  import dds_pkg::*;
#(
  parameter int PHASE_W = 48
) (
  input logic               clk,
  input logic               rst,
  input logic [PHASE_W-1:0] ftw,
  input logic [IDX_W-1:0]   idx_a,
  input logic [IDX_W-1:0]   idx_b,
  input logic [SMP_W-1:0]   smp_a,
  input logic [OUT_W-1:0]   samp_rise,
  input logic [OUT_W-1:0]   samp_fall
);
  logic [SMP_W:0] hi_a;
  assign hi_a = ({1'b0, smp_a} + 6'd1) >> 1;

  AST_RESET_MID: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (samp_rise == MID_OUT && samp_fall == MID_OUT)); // R7

  AST_ZERO_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ftw) == '0) |-> $stable(idx_a)); // R1

  AST_LANES_MEET: assert property (@(posedge clk) disable iff (rst)
    (ftw == '0) |-> (idx_a == idx_b)); // R6

  AST_TABLE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (smp_a >= 5'd1 && smp_a <= 5'd31)); // R2

  AST_DITHER_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (samp_rise == $past(smp_a[SMP_W-1:1]) ||
                     {2'b00, samp_rise} == $past(hi_a) ||
                     samp_rise == OUT_MAX)); // R3

  AST_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(smp_a) == 5'd31) |-> samp_rise == OUT_MAX); // R4
endmodule

bind dithered_sine_dds dds_checker #(.PHASE_W(PHASE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ftw       (ftw),
  .idx_a     (lane_idx[0]),
  .idx_b     (lane_idx[1]),
  .smp_a     (lane_smp[0]),
  .samp_rise (samp_rise),
  .samp_fall (samp_fall)
);

// File: tb/dithered_sine_dds_tb_top.sv
module dithered_sine_dds_tb_top;
  localparam int PW = 48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] ftw = '0;
  logic [3:0]    samp_rise;
  logic [3:0]    samp_fall;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [PW-1:0] m_phase;
  logic [15:0]   m_lfsr;
  logic [3:0]    e_rise, e_fall;
  bit            e_sat;

  always #2 clk = ~clk;

  dithered_sine_dds dut_i (
    .clk(clk), .rst(rst), .ftw(ftw),
    .samp_rise(samp_rise), .samp_fall(samp_fall)
  );

  // R2 table as listed in the requirement
  function automatic int tbl(input logic [3:0] k);
    int t [16] = '{16, 22, 27, 30, 31, 30, 27, 22, 16, 10, 5, 2, 1, 2, 5, 10};
    return t[k];
  endfunction

  // R5 taps 15,13,12,10, shift left
  function automatic logic [15:0] stp(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [3:0] dith(input int s, input logic d);
    int v = (s + int'(d)) / 2;
    return (v > 15) ? 4'd15 : 4'(v);
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock of the reference model (R1, R3, R4, R5, R6)
  task automatic model_edge;
    logic [PW-1:0] mid;
    logic [15:0] l1, l2;
    int sa, sb;
    mid = m_phase + (ftw >> 1);
    l1 = stp(m_lfsr);
    l2 = stp(l1);
    sa = tbl(m_phase[47:44]);
    sb = tbl(mid[47:44]);
    e_rise = dith(sa, l1[0]);
    e_fall = dith(sb, l2[0]);
    e_sat  = (sa == 31 && l1[0]);
    m_phase = m_phase + ftw;
    m_lfsr  = l2;
  endtask

  // called at a negedge; ends at a negedge
  task automatic run(input logic [PW-1:0] f, input int n, input string tag);
    ftw = f;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check({tag, " rise"}, samp_rise, e_rise);
      check({tag, " fall"}, samp_fall, e_fall);
      if (e_sat) check("R4 clamp", samp_rise, 4'd15);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 reset rise", samp_rise, 4'd8);
    check("R7 reset fall", samp_fall, 4'd8);
    rst = 1'b0;
    m_phase = '0;
    m_lfsr  = 16'hACE1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    run(48'h1000_0000_0000, 64,  "R2/R3/R6 step16");
    run(48'h0800_0000_0000, 96,  "R2/R6 step8");
    run(48'h0000_0000_0000, 40,  "R1 hold");
    run(48'h8000_0000_0000, 40,  "R1 halfturn");
    run(48'hFFFF_FFFF_FFFF, 80,  "R1 reverse");
    run(48'h0123_4567_89AB, 300, "R8 dense");
    run(48'h1800_0000_0000, 100, "R8 retune");
    do_reset();
    run(48'h0400_0000_0001, 200, "R7/R5 restart");
    run(48'h1000_0000_0000, 64,  "R4 sweep");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule